// File: doc/BRIEF.md
# DDR2 power-up and calibration sequencer

This block sits on the controller side of a DDR2 memory path and brings the device out of power-up on its own once reset is released. It holds the clock enable low for a programmable power-up interval, raises it, and then issues the required sequence on the command bus. That sequence is two precharge-all operations, the mode and extended-mode register loads, two refreshes and the DLL lock interval. Between commands it enforces parameterised minimum gaps, counted in clock cycles, and it drives NOP in every cycle that carries no command.

When the mode setup is complete the sequencer goes straight on to calibration. It opens one row and issues two write/read pairs. After each read it raises a request to an external capture path and waits for a one-cycle done pulse. When the second read has been acknowledged, the sequencer raises its initialization-done flag and holds it until the next reset. If the capture path does not answer within a programmable number of cycles, the sequencer raises an error flag instead, stops issuing commands, and the done flag stays low.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low the outputs are idle: `cke_o` is 0, the command pins `{cs_n_o,ras_n_o,cas_n_o,we_n_o}` show NOP (4'b0111), and `init_done_o`, `err_o` and `cal_req_o` are 0.
- R2: After reset is released, `cke_o` stays low for PWRUP_CYC cycles with NOP on the bus. It then rises and stays high, and the first command follows CKE_LEAD cycles after the rise.
- R3: The commands appear in this order, with the pin code `{cs_n,ras_n,cas_n,we_n}` shown in brackets: PRE (0010) with addr bit 10 set; then MRS (0000) to bank 2, bank 3 and bank 1 with address EMR_BASE; then MRS to bank 0 with MR_BASE and addr bit 8 set; then PRE; then REF (0001) twice; then MRS to bank 0 with MR_BASE; then MRS to bank 1 with EMR_BASE and bits 9:7 all set; then MRS to bank 1 with EMR_BASE; then ACT (0011) to bank 0, row CAL_ROW; then WR (0100) at column CAL_COL1, RD (0101) at CAL_COL1, WR at CAL_COL2 and RD at CAL_COL2.
- R4: Command-to-command spacing is exact. It is T_RP after each precharge, T_MRD after each mode load except the last, T_RFC after each refresh, DLL_LOCK after the last mode load, T_RCD after the activate, and T_CAL after each calibration write.
- R5: Every cycle that does not carry one of the listed commands drives NOP, and no other command is ever issued.
- R6: `cal_req_o` is high from the cycle after each calibration read until the cycle in which `cal_done_i` is sampled high. The next step begins in the following cycle.
- R7: If `cal_done_i` is not seen within CAL_TIMEOUT cycles after a calibration read, `err_o` rises in the next cycle and stays high. No further command is issued and `init_done_o` stays low. A pulse in exactly the last allowed cycle is still accepted.
- R8: `init_done_o` rises in the cycle after the second read's done pulse. It stays high until reset, and afterwards no command is issued and `cal_done_i` has no effect.
- R9: A `cal_done_i` pulse while no calibration read is pending does not change the command timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_done_i | input | 1 | One-cycle acknowledge from the capture path |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row, column or mode-register address |
| cal_req_o | output | 1 | Capture path armed, waiting for acknowledge |
| init_done_o | output | 1 | Initialization and calibration complete |
| err_o | output | 1 | Calibration acknowledge timed out |

## Verification
The step register has to be one entry off, or the shared counter loaded with a wrong value, for the block to misbehave. Either fault reaches the command pins at the next command issue. It then appears as a wrong pin code, bank or address, or as a gap that is off by some cycles against the exact spacing the bench expects. A fault in the calibration wait shows up differently. It appears as the request held for the wrong number of cycles, as an error flag that rises one cycle early or late, or as a done flag that appears after a timeout. The bench times every command against the moment the clock enable rises, so a fault shows within one command interval of the point where it occurs.

// File: rtl/ddr2_init_pkg.sv
// Shared types for the DDR2 power-up sequencer.
// Assumes the step list below is in issue order; the successor of a step
// is the next enum value.
package ddr2_init_pkg;

    // Command pin code {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_PWR,  ST_CKE,  ST_PRE1, ST_EMR2, ST_EMR3, ST_EDLL,
        ST_MRST, ST_PRE2, ST_REF1, ST_REF2, ST_MR,   ST_OCDD, ST_OCDX,
        ST_ACT,  ST_WR1,  ST_RD1,  ST_WR2,  ST_RD2,  ST_DONE, ST_ERR
    } step_e;

    typedef enum logic [1:0] {
        PH_ISSUE,
        PH_WAIT,
        PH_CAL
    } phase_e;

    function automatic step_e step_after(step_e s);
        return step_e'(s + 5'd1);
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
// Down-counter shared by every timed step.
// Assumes a load value of at least 1; "last" marks the final counted cycle.
module ddr2_init_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));

endmodule

// File: rtl/ddr2_init_cmdgen.sv
// Per-step decode: the command, bank, address, clock enable and spacing
// of each step. Purely combinational; assumes all spacings are at least 2,
// except the single-cycle idle step.
module ddr2_init_cmdgen
    import ddr2_init_pkg::*;
#(
    parameter int unsigned BA_W      = 3,
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PWRUP_CYC = 10000,
    parameter int unsigned CKE_LEAD  = 20,
    parameter int unsigned T_RP      = 4,
    parameter int unsigned T_MRD     = 2,
    parameter int unsigned T_RFC     = 26,
    parameter int unsigned T_RCD     = 4,
    parameter int unsigned T_CAL     = 6,
    parameter int unsigned DLL_LOCK  = 200,
    parameter logic [ADDR_W-1:0] MR_BASE  = 14'h0643,
    parameter logic [ADDR_W-1:0] EMR_BASE = 14'h0000,
    parameter logic [ADDR_W-1:0] CAL_ROW  = 14'h0000,
    parameter logic [ADDR_W-1:0] CAL_COL1 = 14'h0000,
    parameter logic [ADDR_W-1:0] CAL_COL2 = 14'h0008
) (
    input  step_e              step,
    output cmd_e               cmd,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr,
    output logic               cke,
    output logic [CNT_W-1:0]   gap,
    output logic               is_read
);

    localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << 10;
    localparam logic [ADDR_W-1:0] DLL_RST = ADDR_W'(1) << 8;
    localparam logic [ADDR_W-1:0] OCD_DEF = ADDR_W'(7) << 7;

    // Table of step attributes.
    always_comb begin
        cmd     = CMD_NOP;
        ba      = '0;
        addr    = '0;
        cke     = 1'b1;
        gap     = CNT_W'(1);
        is_read = 1'b0;
        unique case (step)
            ST_IDLE: cke = 1'b0;
            ST_PWR:  begin cke = 1'b0; gap = CNT_W'(PWRUP_CYC); end
            ST_CKE:  gap = CNT_W'(CKE_LEAD);
            ST_PRE1, ST_PRE2: begin
                cmd = CMD_PRE; addr = PRE_ALL; gap = CNT_W'(T_RP);
            end
            ST_EMR2: begin cmd = CMD_MRS; ba = BA_W'(2); addr = EMR_BASE; gap = CNT_W'(T_MRD); end
            ST_EMR3: begin cmd = CMD_MRS; ba = BA_W'(3); addr = EMR_BASE; gap = CNT_W'(T_MRD); end
            ST_EDLL: begin cmd = CMD_MRS; ba = BA_W'(1); addr = EMR_BASE; gap = CNT_W'(T_MRD); end
            ST_MRST: begin cmd = CMD_MRS; addr = MR_BASE | DLL_RST; gap = CNT_W'(T_MRD); end
            ST_REF1, ST_REF2: begin cmd = CMD_REF; gap = CNT_W'(T_RFC); end
            ST_MR:   begin cmd = CMD_MRS; addr = MR_BASE; gap = CNT_W'(T_MRD); end
            ST_OCDD: begin cmd = CMD_MRS; ba = BA_W'(1); addr = EMR_BASE | OCD_DEF; gap = CNT_W'(T_MRD); end
            ST_OCDX: begin cmd = CMD_MRS; ba = BA_W'(1); addr = EMR_BASE; gap = CNT_W'(DLL_LOCK); end
            ST_ACT:  begin cmd = CMD_ACT; addr = CAL_ROW; gap = CNT_W'(T_RCD); end
            ST_WR1:  begin cmd = CMD_WR; addr = CAL_COL1; gap = CNT_W'(T_CAL); end
            ST_RD1:  begin cmd = CMD_RD; addr = CAL_COL1; is_read = 1'b1; end
            ST_WR2:  begin cmd = CMD_WR; addr = CAL_COL2; gap = CNT_W'(T_CAL); end
            ST_RD2:  begin cmd = CMD_RD; addr = CAL_COL2; is_read = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up, mode setup and calibration sequencer.
// Each step issues its command for one cycle, then waits out its spacing
// with NOP on the bus; calibration reads instead wait for an acknowledge
// with a timeout. Assumes DLL_LOCK >= T_MRD, all spacings >= 2 and
// CAL_TIMEOUT >= 1.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned BA_W        = 3,
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned PWRUP_CYC   = 10000,
    parameter int unsigned CKE_LEAD    = 20,
    parameter int unsigned T_RP        = 4,
    parameter int unsigned T_MRD       = 2,
    parameter int unsigned T_RFC       = 26,
    parameter int unsigned T_RCD       = 4,
    parameter int unsigned T_CAL       = 6,
    parameter int unsigned DLL_LOCK    = 200,
    parameter int unsigned CAL_TIMEOUT = 64,
    parameter logic [ADDR_W-1:0] MR_BASE  = 14'h0643,
    parameter logic [ADDR_W-1:0] EMR_BASE = 14'h0000,
    parameter logic [ADDR_W-1:0] CAL_ROW  = 14'h0000,
    parameter logic [ADDR_W-1:0] CAL_COL1 = 14'h0000,
    parameter logic [ADDR_W-1:0] CAL_COL2 = 14'h0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_done_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cal_req_o,
    output logic              init_done_o,
    output logic              err_o
);

    localparam int unsigned SPAN  = PWRUP_CYC + CKE_LEAD + T_RP + T_MRD + T_RFC
                                  + T_RCD + T_CAL + DLL_LOCK + CAL_TIMEOUT;
    localparam int unsigned CNT_W = $clog2(SPAN + 1);

    step_e              step;
    phase_e             phase;
    cmd_e               step_cmd;
    logic [BA_W-1:0]    step_ba;
    logic [ADDR_W-1:0]  step_addr;
    logic               step_cke;
    logic [CNT_W-1:0]   step_gap;
    logic               step_rd;
    logic               t_load;
    logic [CNT_W-1:0]   t_val;
    logic               t_last;
    logic               issuing;
    logic               final_step;

    ddr2_init_cmdgen #(
        .BA_W(BA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .PWRUP_CYC(PWRUP_CYC), .CKE_LEAD(CKE_LEAD), .T_RP(T_RP),
        .T_MRD(T_MRD), .T_RFC(T_RFC), .T_RCD(T_RCD), .T_CAL(T_CAL),
        .DLL_LOCK(DLL_LOCK), .MR_BASE(MR_BASE), .EMR_BASE(EMR_BASE),
        .CAL_ROW(CAL_ROW), .CAL_COL1(CAL_COL1), .CAL_COL2(CAL_COL2)
    ) u_cmdgen (
        .step(step), .cmd(step_cmd), .ba(step_ba), .addr(step_addr),
        .cke(step_cke), .gap(step_gap), .is_read(step_rd)
    );

    ddr2_init_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
    );

    assign issuing    = (phase == PH_ISSUE);
    assign final_step = (step == ST_DONE) || (step == ST_ERR);

    // Arm the timer in each issue cycle: spacing minus one, or the timeout.
    assign t_load = issuing;
    assign t_val  = step_rd ? CNT_W'(CAL_TIMEOUT) : step_gap - 1'b1;

    // Step and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= ST_IDLE;
            phase <= PH_ISSUE;
        end else begin
            unique case (phase)
                PH_ISSUE: begin
                    if (final_step)
                        phase <= PH_ISSUE;
                    else if (step_rd)
                        phase <= PH_CAL;
                    else if (step_gap == CNT_W'(1))
                        step <= step_after(step);
                    else
                        phase <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (t_last) begin
                        step  <= step_after(step);
                        phase <= PH_ISSUE;
                    end
                end
                PH_CAL: begin
                    if (cal_done_i) begin
                        step  <= step_after(step);
                        phase <= PH_ISSUE;
                    end else if (t_last) begin
                        step  <= ST_ERR;
                        phase <= PH_ISSUE;
                    end
                end
                default: phase <= PH_ISSUE;
            endcase
        end
    end

    // Pin decode: the step's command only in its issue cycle, else NOP.
    always_comb begin
        {cs_n_o, ras_n_o, cas_n_o, we_n_o} = issuing ? step_cmd : CMD_NOP;
        ba_o   = issuing ? step_ba   : '0;
        addr_o = issuing ? step_addr : '0;
    end

    assign cke_o       = step_cke;
    assign cal_req_o   = (phase == PH_CAL);
    assign init_done_o = (step == ST_DONE);
    assign err_o       = (step == ST_ERR);

endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Protocol checker for the DDR2 sequencer, bound to every instance.
// Assumes the default spacings (all at least 2).
module ddr2_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke_o,
    input logic [3:0] cmd,
    input logic       cal_req_o,
    input logic       init_done_o,
    input logic       err_o
);

    localparam logic [3:0] NOP = 4'b0111;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!cke_o && cmd == NOP && !init_done_o && !err_o && !cal_req_o));

    // R2
    cke_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cke_o) |-> cke_o);

    // R2
    cke_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> cmd == NOP);

    // R5
    nop_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != NOP |=> cmd == NOP);

    // R6
    req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req_o |-> cmd == NOP);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o && !init_done_o && cmd == NOP));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> (init_done_o && !err_o && cmd == NOP && !cal_req_o));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cke_o(cke_o),
    .cmd({cs_n_o, ras_n_o, cas_n_o, we_n_o}),
    .cal_req_o(cal_req_o), .init_done_o(init_done_o), .err_o(err_o)
);

// File: tb/ddr2_init_seq_test.sv
// Bench for the DDR2 sequencer: logs every command with its cycle and
// compares order, fields and spacing against a table of expectations.
module ddr2_init_seq_test;

    localparam int PWRUP = 10000;
    localparam int LEAD  = 20;
    localparam int TRP   = 4;
    localparam int TMRD  = 2;
    localparam int TRFC  = 26;
    localparam int TRCD  = 4;
    localparam int TCAL  = 6;
    localparam int DLL   = 200;
    localparam int TOUT  = 64;

    // {pin code, bank, address, spacing to next command (0 = acknowledge driven)}
    localparam logic [36:0] EXP [16] = '{
        {4'h2, 3'd0, 14'h0400, 16'(TRP)},
        {4'h0, 3'd2, 14'h0000, 16'(TMRD)},
        {4'h0, 3'd3, 14'h0000, 16'(TMRD)},
        {4'h0, 3'd1, 14'h0000, 16'(TMRD)},
        {4'h0, 3'd0, 14'h0743, 16'(TMRD)},
        {4'h2, 3'd0, 14'h0400, 16'(TRP)},
        {4'h1, 3'd0, 14'h0000, 16'(TRFC)},
        {4'h1, 3'd0, 14'h0000, 16'(TRFC)},
        {4'h0, 3'd0, 14'h0643, 16'(TMRD)},
        {4'h0, 3'd1, 14'h0380, 16'(TMRD)},
        {4'h0, 3'd1, 14'h0000, 16'(DLL)},
        {4'h3, 3'd0, 14'h0000, 16'(TRCD)},
        {4'h4, 3'd0, 14'h0000, 16'(TCAL)},
        {4'h5, 3'd0, 14'h0000, 16'd0},
        {4'h4, 3'd0, 14'h0008, 16'(TCAL)},
        {4'h5, 3'd0, 14'h0008, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resp_done = 1'b0;
    logic        inj_done = 1'b0;
    logic        cal_done;
    logic        cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
    logic [2:0]  ba_o;
    logic [13:0] addr_o;
    logic        cal_req_o, init_done_o, err_o;
    logic [3:0]  cmd;

    assign cal_done = resp_done | inj_done;
    assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

    ddr2_init_seq #(
        .PWRUP_CYC(PWRUP), .CKE_LEAD(LEAD), .T_RP(TRP), .T_MRD(TMRD),
        .T_RFC(TRFC), .T_RCD(TRCD), .T_CAL(TCAL), .DLL_LOCK(DLL),
        .CAL_TIMEOUT(TOUT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cal_done_i(cal_done), .cke_o(cke_o),
        .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .ba_o(ba_o), .addr_o(addr_o), .cal_req_o(cal_req_o),
        .init_done_o(init_done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_ev, cke_rise, done_at, err_at, req_cnt, rd_num, wcnt;
    bit cke_drop;
    int ev_cmd [32];
    int ev_ba [32];
    int ev_addr [32];
    int ev_t [32];
    int dly1 = 1;
    int dly2 = 1;

    // Cycle count since reset release.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Command and flag monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            n_ev = 0; cke_rise = -1; done_at = -1; err_at = -1;
            req_cnt = 0; cke_drop = 1'b0;
        end else begin
            if (cmd != 4'h7) begin
                if (n_ev < 32) begin
                    ev_cmd[n_ev] = int'(cmd); ev_ba[n_ev] = int'(ba_o);
                    ev_addr[n_ev] = int'(addr_o); ev_t[n_ev] = cyc;
                end
                n_ev++;
            end
            if (cke_o && cke_rise < 0) cke_rise = cyc;
            if (cke_rise >= 0 && !cke_o) cke_drop = 1'b1;
            if (init_done_o && done_at < 0) done_at = cyc;
            if (err_o && err_at < 0) err_at = cyc;
            if (cal_req_o) req_cnt++;
        end
    end

    // Capture-path model: acknowledge after a per-read delay.
    always @(negedge clk) begin
        if (!rst_n) begin
            resp_done <= 1'b0; wcnt <= 0; rd_num <= 0;
        end else if (resp_done) begin
            resp_done <= 1'b0; rd_num <= rd_num + 1;
        end else if (cal_req_o) begin
            if (wcnt == ((rd_num == 0) ? dly1 : dly2) - 1) begin
                resp_done <= 1'b1; wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            wcnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_inj();
        inj_done = 1'b1;
        @(negedge clk);
        inj_done = 1'b0;
    endtask

    // One full sequence: reset, release, wait for an end state, then check.
    task automatic run(input int d1, input int d2, input bit inject, input int nev_exp);
        int frozen;
        bit injected;
        injected = 1'b0;
        dly1 = d1; dly2 = d2;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cke_o == 1'b0, "R1", "cke in reset", int'(cke_o), 0);
        chk(cmd == 4'h7, "R1", "command in reset", int'(cmd), 7);
        chk(!init_done_o && !err_o && !cal_req_o, "R1", "flags in reset",
            int'({init_done_o, err_o, cal_req_o}), 0);
        rst_n = 1'b1;
        for (int k = 0; k < PWRUP + 3000; k++) begin
            @(negedge clk);
            // R9: stray acknowledge during the DLL lock wait
            if (inject && !injected && n_ev == 11 && cyc == ev_t[10] + 5) begin
                injected = 1'b1;
                pulse_inj();
            end
            if (done_at >= 0 || err_at >= 0) break;
        end
        chk(cke_rise == 1 + PWRUP, "R2", "cke rise cycle", cke_rise, 1 + PWRUP);
        if (n_ev > 0)
            chk(ev_t[0] - cke_rise == LEAD, "R2", "cke lead", ev_t[0] - cke_rise, LEAD);
        chk(n_ev == nev_exp, "R5", "command count", n_ev, nev_exp);
        for (int i = 0; i < nev_exp && i < n_ev; i++) begin
            chk(ev_cmd[i] == int'(EXP[i][36:33]), "R3", $sformatf("code of cmd %0d", i),
                ev_cmd[i], int'(EXP[i][36:33]));
            chk(ev_ba[i] == int'(EXP[i][32:30]), "R3", $sformatf("bank of cmd %0d", i),
                ev_ba[i], int'(EXP[i][32:30]));
            chk(ev_addr[i] == int'(EXP[i][29:16]), "R3", $sformatf("addr of cmd %0d", i),
                ev_addr[i], int'(EXP[i][29:16]));
            if (i + 1 < n_ev) begin
                if (EXP[i][15:0] != 16'd0)
                    chk(ev_t[i+1] - ev_t[i] == int'(EXP[i][15:0]), "R4",
                        $sformatf("gap after cmd %0d", i), ev_t[i+1] - ev_t[i],
                        int'(EXP[i][15:0]));
                else
                    chk(ev_t[i+1] - ev_t[i] == d1 + 1, "R6", "read 1 to write 2",
                        ev_t[i+1] - ev_t[i], d1 + 1);
            end
        end
        if (inject && n_ev > 11)
            chk(ev_t[11] - ev_t[10] == DLL, "R9", "lock wait with stray ack",
                ev_t[11] - ev_t[10], DLL);
        if (nev_exp == 16 && d2 <= TOUT) begin
            chk(done_at == ev_t[15] + d2 + 1, "R8", "done rise cycle", done_at, ev_t[15] + d2 + 1);
            chk(err_at < 0, "R8", "no error", err_at, -1);
            chk(req_cnt == d1 + d2, "R6", "request cycles", req_cnt, d1 + d2);
            frozen = n_ev;
            repeat (10) @(negedge clk);
            pulse_inj();
            repeat (200) @(negedge clk);
            chk(init_done_o == 1'b1, "R8", "done held", int'(init_done_o), 1);
            chk(n_ev == frozen, "R8", "quiet after done", n_ev, frozen);
        end else begin
            chk(err_at == ev_t[nev_exp-1] + TOUT + 1, "R7", "error rise cycle",
                err_at, ev_t[nev_exp-1] + TOUT + 1);
            chk(done_at < 0, "R7", "no done after timeout", done_at, -1);
            frozen = n_ev;
            repeat (100) @(negedge clk);
            chk(err_o == 1'b1, "R7", "error held", int'(err_o), 1);
            chk(n_ev == frozen, "R7", "quiet after error", n_ev, frozen);
        end
        chk(!cke_drop, "R2", "cke stays high", int'(cke_drop), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual still running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        run(1, 3, 1'b0, 16);          // R6 R8: short acknowledges
        run(TOUT, 2, 1'b1, 16);       // R7 boundary, R9 stray pulse
        run(TOUT + 1, 1, 1'b0, 14);   // R7: first read times out
        run(2, 1000, 1'b0, 16);       // R7: second read times out
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule